// File: doc/BRIEF.md
# Programmable DRAM Rank Select Decoder

This block sits between an on-chip bus and a DRAM controller that drives two ranks. For each address presented with a valid strobe, it works out which rank, if any, the access belongs to. Each rank has its own 8-bit match value and 8-bit mask. The top byte of the address is ANDed with the mask and compared against the match value. Mask 0xF8 gives a 128 MB rank, 0xF0 gives 256 MB, 0xE0 gives 512 MB and 0xC0 gives 1 GB.

The controller owns only the window whose top byte is 0x20 to 0x3F. No select is ever driven for an address outside that window. The outputs are registered:
- one-hot rank-hit bits,
- two active-low select pins,
- a miss pulse,
- the byte offset inside the chosen rank.

For devices with eight internal banks, an eight-bank mode can be set through rank 0's register. In that mode only rank 0 decodes, and the second select pin carries bank address bit 2 instead of acting as a select.

Software programs the ranks through a single-cycle write port. Typical setups are:
- Two contiguous 128 MB ranks: match 0x20 and 0x28, both with mask 0xF8.
- One 512 MB eight-bank device on rank 0: match 0x20, mask 0xE0, eight-bank mode set.

Top module: `dram_rank_decoder`

## Requirements
- R1: After reset both ranks are disabled, eight-bank mode is off, and all outputs are idle: selects high, rank-hit 0, miss 0, offset 0.
- R2: Only addresses whose top byte lies in 0x20..0x3F are decoded. Any other address leaves both selects high, rank-hit 0 and miss 0, whatever the rank settings.
- R3: Rank n is selected when it is enabled and (addr[31:24] AND mask_n) equals match_n. The result appears on the outputs at the clock edge that samples the valid strobe. rankHit[n] goes to 1, and select pin n (csN[n]) goes to 0.
- R4: If both ranks match, rank 0 wins. At most one rankHit bit is ever set.
- R5: A valid address inside the window that selects no rank raises decodeMiss for exactly that result cycle.
- R6: A cycle with the valid strobe low produces the idle result on the next edge: selects high, rank-hit 0, miss 0, offset 0.
- R7: In eight-bank mode, rank 1 is never selected, and its settings have no effect. When rank 0 is selected, csN[1] equals address bit BANK2_POS (default 13). Otherwise csN[1] is high.
- R8: rankOffset is the address with the bits covered by the selected rank's mask (placed on bits 31:24) cleared. It is 0 when no rank is selected.
- R9: A write with cfgWe high loads the rank picked by cfgRank. The cfgData layout is:
  - [7:0] match value
  - [15:8] mask
  - [16] enable
  - [17] eight-bank mode, taken only on writes to rank 0 and ignored on writes to rank 1

  The new setting governs accesses sampled from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgRank | input | 1 | Rank addressed by the write |
| cfgData | input | 18 | Write data: match, mask, enable, eight-bank |
| addrValid | input | 1 | Address valid strobe |
| addr | input | 32 | Bus address |
| rankHit | output | 2 | One-hot selected rank, registered |
| csN | output | 2 | Active-low select pins; bit 1 is bank bit 2 in eight-bank mode |
| decodeMiss | output | 1 | In-window address matched no rank |
| rankOffset | output | 32 | Offset inside the selected rank |

## Verification
The bench uses the default parameters: a 32-bit address, the 0x20..0x3F window, and bank bit 2 on address bit 13. With these, every mask size and the contiguous two-rank layout can be tested, including the boundary top bytes 0x1F, 0x20, 0x3F and 0x40. Random reconfiguration is mixed with random in-window and out-of-window addresses. This covers overlapping ranks, disabled ranks, and eight-bank mode switching between accesses, so the priority rule, the miss pulse and the bank-bit pin are all exercised under changing settings.

// File: rtl/rankdec_pkg.sv
package rankdec_pkg;
  localparam int TAG_W     = 8;
  localparam int NUM_RANKS = 2;
  localparam int CFG_W     = 2 * TAG_W + 2;

  // strobes from control to datapath
  typedef struct packed {
    logic pick0;
    logic pick1;
    logic miss;
    logic bankMode;
  } dec_strobe_t;
endpackage

// File: rtl/rankdec_regs.sv
module rankdec_regs
  import rankdec_pkg::*;
#(
  parameter int RANKS = NUM_RANKS
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWe,
  input  logic [$clog2(RANKS)-1:0]   cfgRank,
  input  logic [CFG_W-1:0]           cfgData,
  output logic [TAG_W-1:0]           cfgBase [RANKS],
  output logic [TAG_W-1:0]           cfgMask [RANKS],
  output logic                       cfgEn   [RANKS],
  output logic                       eightMode
);
  localparam int EN_BIT    = 2 * TAG_W;
  localparam int EIGHT_BIT = 2 * TAG_W + 1;

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgBase[r] <= '0;
        cfgMask[r] <= '0;
        cfgEn[r]   <= 1'b0;
      end else if (cfgWe && (cfgRank == r)) begin
        cfgBase[r] <= cfgData[TAG_W-1:0];
        cfgMask[r] <= cfgData[2*TAG_W-1:TAG_W];
        cfgEn[r]   <= cfgData[EN_BIT];
      end
    end
  end

  // bank-count mode lives with rank 0 only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          eightMode <= 1'b0;
    else if (cfgWe && (cfgRank == '0))  eightMode <= cfgData[EIGHT_BIT];
  end
endmodule

// File: rtl/rankdec_ctrl.sv
module rankdec_ctrl
  import rankdec_pkg::*;
#(
  parameter logic [TAG_W-1:0] WIN_LO = 8'h20,
  parameter logic [TAG_W-1:0] WIN_HI = 8'h3F
) (
  input  logic             addrValid,
  input  logic [TAG_W-1:0] addrTag,
  input  logic [TAG_W-1:0] cfgBase [NUM_RANKS],
  input  logic [TAG_W-1:0] cfgMask [NUM_RANKS],
  input  logic             cfgEn   [NUM_RANKS],
  input  logic             eightMode,
  output dec_strobe_t      strobe
);
  logic [NUM_RANKS-1:0] tagMatch;
  logic                 inWindow;

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_match
    assign tagMatch[r] = cfgEn[r] && ((addrTag & cfgMask[r]) == cfgBase[r]);
  end

  always_comb begin
    inWindow        = (addrTag >= WIN_LO) && (addrTag <= WIN_HI);
    strobe.pick0    = addrValid && inWindow && tagMatch[0];
    strobe.pick1    = addrValid && inWindow && tagMatch[1] && !tagMatch[0] && !eightMode;
    strobe.miss     = addrValid && inWindow && !strobe.pick0 && !strobe.pick1;
    strobe.bankMode = eightMode;
  end
endmodule

// File: rtl/rankdec_data.sv
module rankdec_data
  import rankdec_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BANK2_POS = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  dec_strobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  cfgMask [NUM_RANKS],
  output logic [1:0]        rankHit,
  output logic [1:0]        csN,
  output logic              decodeMiss,
  output logic [ADDR_W-1:0] rankOffset
);
  localparam int LOW_W = ADDR_W - TAG_W;

  logic [TAG_W-1:0]  maskSel;
  logic [ADDR_W-1:0] keepBits;
  logic [ADDR_W-1:0] offsetNext;
  logic [1:0]        csNext;

  always_comb begin
    maskSel    = strobe.pick0 ? cfgMask[0] : cfgMask[1];
    keepBits   = ~{maskSel, {LOW_W{1'b0}}};
    offsetNext = (strobe.pick0 || strobe.pick1) ? (addr & keepBits) : '0;
    csNext[0]  = ~strobe.pick0;
    if (strobe.bankMode)
      csNext[1] = strobe.pick0 ? addr[BANK2_POS] : 1'b1;
    else
      csNext[1] = ~strobe.pick1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rankHit    <= 2'b00;
      csN        <= 2'b11;
      decodeMiss <= 1'b0;
      rankOffset <= '0;
    end else begin
      rankHit    <= {strobe.pick1, strobe.pick0};
      csN        <= csNext;
      decodeMiss <= strobe.miss;
      rankOffset <= offsetNext;
    end
  end
endmodule

// File: rtl/dram_rank_decoder.sv
module dram_rank_decoder
  import rankdec_pkg::*;
#(
  parameter int               ADDR_W    = 32,
  parameter logic [TAG_W-1:0] WIN_LO    = 8'h20,
  parameter logic [TAG_W-1:0] WIN_HI    = 8'h3F,
  parameter int               BANK2_POS = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic              cfgRank,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addr,
  output logic [1:0]        rankHit,
  output logic [1:0]        csN,
  output logic              decodeMiss,
  output logic [ADDR_W-1:0] rankOffset
);
  logic [TAG_W-1:0] cfgBase [NUM_RANKS];
  logic [TAG_W-1:0] cfgMask [NUM_RANKS];
  logic             cfgEn   [NUM_RANKS];
  logic             eightMode;
  dec_strobe_t      strobe;

  rankdec_regs #(.RANKS(NUM_RANKS)) u_regs (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRank(cfgRank), .cfgData(cfgData),
    .cfgBase(cfgBase), .cfgMask(cfgMask), .cfgEn(cfgEn), .eightMode(eightMode)
  );

  rankdec_ctrl #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_ctrl (
    .addrValid(addrValid), .addrTag(addr[ADDR_W-1 -: TAG_W]),
    .cfgBase(cfgBase), .cfgMask(cfgMask), .cfgEn(cfgEn),
    .eightMode(eightMode), .strobe(strobe)
  );

  rankdec_data #(.ADDR_W(ADDR_W), .BANK2_POS(BANK2_POS)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr), .cfgMask(cfgMask),
    .rankHit(rankHit), .csN(csN), .decodeMiss(decodeMiss), .rankOffset(rankOffset)
  );
endmodule

// File: rtl/rankdec_checker.sv
module rankdec_checker
  import rankdec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrValid,
  input logic [ADDR_W-1:0] addr,
  input logic [TAG_W-1:0]  cfgBase [NUM_RANKS],
  input logic [TAG_W-1:0]  cfgMask [NUM_RANKS],
  input logic              cfgEn   [NUM_RANKS],
  input logic              eightMode,
  input logic [1:0]        rankHit,
  input logic [1:0]        csN,
  input logic              decodeMiss,
  input logic [ADDR_W-1:0] rankOffset
);
  logic [TAG_W-1:0] tag;
  logic             inWin;
  assign tag   = addr[ADDR_W-1 -: TAG_W];
  assign inWin = (tag >= 8'h20) && (tag <= 8'h3F);

  assert_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> (csN == 2'b11 && rankHit == 2'b00 && !decodeMiss && rankOffset == '0));

  assert_outside_R2: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !inWin) |=> (csN == 2'b11 && rankHit == 2'b00 && !decodeMiss));

  assert_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rankHit));

  assert_prio_R4: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && inWin && cfgEn[0] && ((tag & cfgMask[0]) == cfgBase[0])) |=> (rankHit == 2'b01));

  assert_miss_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    decodeMiss |-> (rankHit == 2'b00 && csN[0]));

  assert_eight_R7: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && eightMode) |=> !rankHit[1]);

  assert_nohit_offset_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rankHit == 2'b00) |-> (rankOffset == '0));
endmodule

bind dram_rank_decoder rankdec_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .addrValid(addrValid), .addr(addr),
  .cfgBase(cfgBase), .cfgMask(cfgMask), .cfgEn(cfgEn), .eightMode(eightMode),
  .rankHit(rankHit), .csN(csN), .decodeMiss(decodeMiss), .rankOffset(rankOffset)
);

// File: tb/sim_dram_rank_decoder.sv
module sim_dram_rank_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic        cfgRank = 1'b0;
  logic [17:0] cfgData = '0;
  logic        addrValid = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  rankHit;
  logic [1:0]  csN;
  logic        decodeMiss;
  logic [31:0] rankOffset;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench copy of the programmed settings
  logic [7:0] mBase [2] = '{8'h00, 8'h00};
  logic [7:0] mMask [2] = '{8'h00, 8'h00};
  logic       mEn   [2] = '{1'b0, 1'b0};
  logic       mEight = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dram_rank_decoder u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgRank(cfgRank), .cfgData(cfgData),
    .addrValid(addrValid), .addr(addr), .rankHit(rankHit), .csN(csN),
    .decodeMiss(decodeMiss), .rankOffset(rankOffset)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected result from the requirements
  task automatic predict(input logic [31:0] a, output logic [1:0] eHit, output logic [1:0] eCs,
                         output logic eMiss, output logic [31:0] eOff);
    logic [7:0] t;
    logic inWin, m0, m1, p0, p1;
    t     = a[31:24];
    inWin = (t >= 8'h20) && (t <= 8'h3F);
    m0    = mEn[0] && ((t & mMask[0]) == mBase[0]);
    m1    = mEn[1] && ((t & mMask[1]) == mBase[1]);
    p0    = inWin && m0;
    p1    = inWin && m1 && !m0 && !mEight;
    eHit  = {p1, p0};
    eMiss = inWin && !p0 && !p1;
    eCs[0] = !p0;
    eCs[1] = mEight ? (p0 ? a[13] : 1'b1) : !p1;
    eOff  = p0 ? (a & ~{mMask[0], 24'h0}) : p1 ? (a & ~{mMask[1], 24'h0}) : 32'h0;
  endtask

  // R9: write port, effective from the next access
  task automatic writeCfg(input logic rk, input logic eight, input logic en,
                          input logic [7:0] mask, input logic [7:0] base);
    cfgWe = 1'b1; cfgRank = rk; cfgData = {eight, en, mask, base};
    @(negedge clk);
    cfgWe = 1'b0;
    mBase[rk] = base; mMask[rk] = mask; mEn[rk] = en;
    if (rk == 1'b0) mEight = eight;
  endtask

  task automatic access(input string req, input logic [31:0] a);
    logic [1:0] eHit, eCs;
    logic eMiss;
    logic [31:0] eOff;
    addrValid = 1'b1; addr = a;
    @(negedge clk);
    predict(a, eHit, eCs, eMiss, eOff);
    check(req, {27'h0, rankHit, csN, decodeMiss, rankOffset}, {27'h0, eHit, eCs, eMiss, eOff});
  endtask

  task automatic idle(input string req, input logic [31:0] a);
    addrValid = 1'b0; addr = a;
    @(negedge clk);
    check(req, {27'h0, rankHit, csN, decodeMiss, rankOffset}, {27'h0, 2'b00, 2'b11, 1'b0, 32'h0});
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset outputs", {27'h0, rankHit, csN, decodeMiss, rankOffset}, {27'h0, 2'b00, 2'b11, 1'b0, 32'h0});
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle after reset", {27'h0, rankHit, csN, decodeMiss, rankOffset}, {27'h0, 2'b00, 2'b11, 1'b0, 32'h0});
    // R1/R5: ranks disabled out of reset, in-window access misses
    access("R5 miss with ranks disabled", 32'h2300_0000);
    check("R1 disabled gives miss", {63'h0, decodeMiss}, 64'h1);

    // R3/R8: two contiguous 128 MB ranks
    writeCfg(1'b0, 1'b0, 1'b1, 8'hF8, 8'h20);
    writeCfg(1'b1, 1'b0, 1'b1, 8'hF8, 8'h28);
    access("R3 rank0 hit", 32'h2312_3456);
    check("R8 rank0 offset", {32'h0, rankOffset}, {32'h0, 32'h0312_3456});
    access("R3 rank1 hit", 32'h28AB_CDEF);
    check("R3 rank1 pins", {62'h0, csN}, {62'h0, 2'b01});
    access("R5 miss in window", 32'h3000_0000);
    check("R5 miss flag", {63'h0, decodeMiss}, 64'h1);
    // R5: miss lasts one cycle
    idle("R6 idle after miss", 32'h3000_0000);
    // R2: window edges
    access("R2 below window 0x1F", 32'h1F00_0000);
    access("R2 window low edge", 32'h2000_0000);
    access("R2 window high edge", 32'h3FFF_FFFF);
    writeCfg(1'b1, 1'b0, 1'b1, 8'hF8, 8'h40);
    access("R2 above window", 32'h4000_0010);
    check("R2 no select outside", {61'h0, csN, decodeMiss}, {61'h0, 2'b11, 1'b0});

    // R4: overlap, rank 0 wins
    writeCfg(1'b0, 1'b0, 1'b1, 8'hE0, 8'h20);
    writeCfg(1'b1, 1'b0, 1'b1, 8'hF8, 8'h28);
    access("R4 priority", 32'h2800_0000);
    check("R4 rank0 wins", {62'h0, rankHit}, {62'h0, 2'b01});
    // R6: valid low with a hitting address
    idle("R6 valid low", 32'h2800_0000);
    // R3: 1 GB rank with base 0x00 mask 0xC0
    writeCfg(1'b0, 1'b0, 1'b1, 8'hC0, 8'h00);
    access("R3 1GB rank", 32'h3F00_1234);
    check("R8 1GB offset", {32'h0, rankOffset}, {32'h0, 32'h3F00_1234});

    // R7: eight-bank mode
    writeCfg(1'b0, 1'b1, 1'b1, 8'hF0, 8'h20);
    writeCfg(1'b1, 1'b0, 1'b1, 8'hF0, 8'h30);
    access("R7 bank bit high", 32'h2800_2000);
    check("R7 pin1 bank=1", {62'h0, csN}, {62'h0, 2'b10});
    access("R7 bank bit low", 32'h2800_0000);
    check("R7 pin1 bank=0", {62'h0, csN}, {62'h0, 2'b00});
    access("R7 rank1 ignored", 32'h3000_2000);
    check("R7 rank1 ignored miss", {61'h0, csN, decodeMiss}, {61'h0, 2'b11, 1'b1});
    // R9: rank1 write does not touch eight-bank mode
    writeCfg(1'b1, 1'b0, 1'b1, 8'hF0, 8'h30);
    access("R9 mode kept", 32'h2000_2000);
    check("R9 rank1 write keeps mode", {62'h0, csN}, {62'h0, 2'b10});
    // R9: leave eight-bank mode and see the next access follow
    writeCfg(1'b0, 1'b0, 1'b1, 8'hF0, 8'h20);
    access("R9 new setting next access", 32'h3000_0000);
    check("R9 rank1 back", {62'h0, rankHit}, {62'h0, 2'b10});

    // random mix
    for (int i = 0; i < 400; i++) begin
      int pick;
      pick = $urandom_range(0, 9);
      if (pick == 0) begin
        logic [7:0] mk;
        logic [7:0] bs;
        int s;
        s  = $urandom_range(0, 3);
        mk = (s == 0) ? 8'hF8 : (s == 1) ? 8'hF0 : (s == 2) ? 8'hE0 : 8'hC0;
        bs = 8'($urandom_range(0, 255)) & mk;
        writeCfg(1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
                 ($urandom_range(0, 5) != 0), mk, bs);
      end else if (pick == 1) begin
        idle("R6 random idle", $urandom);
      end else begin
        logic [31:0] a;
        a = $urandom;
        if ($urandom_range(0, 4) != 0) a[31:24] = 8'($urandom_range(8'h20, 8'h3F));
        access("R3 R4 R7 R8 random", a);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule